// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block is the hazard controller of a five-stage in-order pipeline that settles conditional branches and jumps while they sit in the decode stage. Each cycle it looks at the kind of instruction in decode and the two registers a branch compares. It also looks at the destination register and writer kind of the instructions now in EX, MEM and WB. From these it decides three things: whether decode must wait, where each comparator operand comes from, and whether the instruction just fetched must be discarded.

A single stall output has three effects on the surrounding datapath. The PC and the fetch/decode register keep their values, and the control bits written into the decode/execute register are cleared, which places a bubble there. A fetch-flush output clears the instruction field of the fetch/decode register, which turns the wrong-path fetch into a no-op. The datapath applies the two forwarding selects to the comparator inputs. The unit is purely combinational in its decisions. A load feeding a branch costs two cycles because the same rule fires again as the load moves from EX into MEM.

Top module: `branch_hazard_unit`

## Requirements
- R1: When decode holds a jump (decode kind 2), fetch_flush is 1 and stall is 0, whatever the later stages hold.
- R2: A branch (decode kind 1) with no pending dependency raises fetch_flush exactly when the comparator reports taken (`id_taken`=1), and never stalls.
- R3: A branch stalls when EX holds an ALU writer (writer kind 1) whose destination equals either compare source.
- R4: A branch stalls when EX holds a load (writer kind 2) to one of its sources. It also stalls when MEM holds such a load. A load directly before a branch therefore costs two stall cycles.
- R5: An ALU writer in MEM whose destination matches a source sets that operand's select to 1 (the MEM-stage result), with no stall.
- R6: A writer of either kind in WB whose destination matches a source sets the select to 2 (the WB-stage result), with no stall. A matching ALU writer in MEM takes priority over WB and gives select 1.
- R7: Register 0 is never a dependency. A zero source yields select 0 (register file) and causes no stall.
- R8: When stall is 1, fetch_flush is 0, even if the branch reports taken.
- R9: A decode instruction that is neither branch nor jump (kind 0) never stalls, never flushes, and gets select 0 on both operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the property checks |
| rst_n | input | 1 | Synchronous active-low reset |
| id_kind | input | 2 | Decode instruction kind: 0 other, 1 branch, 2 jump |
| id_taken | input | 1 | Comparator result for the decode branch |
| id_src_a | input | REG_AW | First compare source register |
| id_src_b | input | REG_AW | Second compare source register |
| ex_kind | input | 2 | EX writer kind: 0 none, 1 ALU, 2 load |
| ex_dst | input | REG_AW | EX destination register |
| mem_kind | input | 2 | MEM writer kind |
| mem_dst | input | REG_AW | MEM destination register |
| wb_kind | input | 2 | WB writer kind |
| wb_dst | input | REG_AW | WB destination register |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into decode/execute |
| fetch_flush | output | 1 | Clear the instruction in the fetch/decode register |
| fwd_sel_a | output | 2 | Operand A source: 0 register file, 1 MEM result, 2 WB result |
| fwd_sel_b | output | 2 | Operand B source, same encoding |

## Verification
The bench builds the block with its default register-address width of 5 bits. That width allows distinct nonzero registers to be placed in every stage at once, so the MEM-over-WB priority and the two-operand cases can be reached. Register 0 can also be mixed in to check that it is excluded. A load-then-branch sequence is stepped through three cycles, with the load in EX, then MEM, then WB. This confirms the two-cycle cost followed by a forwarded, flushing resolution.

// File: rtl/bhu_pkg.sv
// Shared encodings for the decode-stage branch hazard unit.
// Assumes: each stage reports at most one destination register.
package bhu_pkg;

    // Kind of the instruction in decode
    typedef enum logic [1:0] {
        ID_OTHER  = 2'd0,
        ID_BRANCH = 2'd1,
        ID_JUMP   = 2'd2
    } id_kind_e;

    // Kind of register writer in a later stage
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_ALU  = 2'd1,
        WR_LOAD = 2'd2
    } wr_kind_e;

    // Comparator operand source
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } opnd_src_e;

    // Later stages observed, in order EX, MEM, WB
    localparam int unsigned N_STAGES = 3;
    localparam int unsigned ST_EX    = 0;
    localparam int unsigned ST_MEM   = 1;
    localparam int unsigned ST_WB    = 2;

endpackage

// File: rtl/bhu_stage_match.sv
// Compares one compare-source register against one stage's destination.
// Reports separate hits for an ALU writer and a load writer.
// Assumes: register 0 is hard-wired to zero and is never a real dependency.
module bhu_stage_match
    import bhu_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic [1:0]        kind,
    output logic              hit_alu,
    output logic              hit_load
);

    logic same_reg;

    // Address match, excluding register 0
    always_comb begin
        same_reg = (src == dst) && (src != '0);
    end

    // Qualify the match by the writer kind
    always_comb begin
        hit_alu  = same_reg && (wr_kind_e'(kind) == WR_ALU);
        hit_load = same_reg && (wr_kind_e'(kind) == WR_LOAD);
    end

endmodule

// File: rtl/bhu_operand.sv
// Hazard evaluation for one comparator operand.
// Decides whether the operand is still being produced (stall needed)
// or whether it can be taken from a later stage (forward select).
// Assumes: the regfile writes before it reads, so a value leaving WB
// this cycle is also offered on the WB forwarding path.
module bhu_operand
    import bhu_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [REG_AW-1:0]                  src,
    input  logic [N_STAGES-1:0][REG_AW-1:0]    dst,
    input  logic [N_STAGES-1:0][1:0]           kind,
    output logic                               need_stall,
    output logic [1:0]                         sel
);

    logic [N_STAGES-1:0] hit_alu;
    logic [N_STAGES-1:0] hit_load;

    // One comparator per observed stage
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        bhu_stage_match #(.REG_AW(REG_AW)) u_match (
            .src      (src),
            .dst      (dst[s]),
            .kind     (kind[s]),
            .hit_alu  (hit_alu[s]),
            .hit_load (hit_load[s])
        );
    end

    // Value not yet available: any writer in EX, or a load still in MEM
    always_comb begin
        need_stall = hit_alu[ST_EX] || hit_load[ST_EX] || hit_load[ST_MEM];
    end

    // Nearest producer wins: ALU result in MEM, then any result in WB
    always_comb begin
        if (hit_alu[ST_MEM])
            sel = SRC_MEM;
        else if (hit_alu[ST_WB] || hit_load[ST_WB])
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end

    // R7: a zero source never stalls and always reads the register file
    a_r7_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (!need_stall && sel == SRC_RF));

    // R4: a load in MEM feeding this operand must hold decode
    a_r4_load_in_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind_e'(kind[ST_MEM]) == WR_LOAD && dst[ST_MEM] == src && src != '0)
            |-> need_stall);

    // R5: an ALU result in MEM is forwarded, never from WB or the regfile
    a_r5_mem_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind_e'(kind[ST_MEM]) == WR_ALU && dst[ST_MEM] == src && src != '0)
            |-> (sel == SRC_MEM));

endmodule

// File: rtl/branch_hazard_unit.sv
// Decode-stage branch hazard unit.
// Combines the per-operand hazard checks into one stall request, gives
// the comparator forwarding selects, and raises the fetch flush for jumps
// and taken branches. A stall always suppresses the flush in the same cycle.
// Assumes: jumps carry no register operands; the datapath applies the
// stall to the PC, the fetch/decode register and the decode/execute bubble.
module branch_hazard_unit
    import bhu_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        id_kind,
    input  logic              id_taken,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [1:0]        ex_kind,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [1:0]        mem_kind,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [1:0]        wb_kind,
    input  logic [REG_AW-1:0] wb_dst,
    output logic              stall,
    output logic              fetch_flush,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);

    localparam int unsigned N_OPS = 2;

    logic [N_STAGES-1:0][REG_AW-1:0] stage_dst;
    logic [N_STAGES-1:0][1:0]        stage_kind;
    logic [N_OPS-1:0][REG_AW-1:0]    op_src;
    logic [N_OPS-1:0]                op_stall;
    logic [N_OPS-1:0][1:0]           op_sel;
    logic                            is_branch;
    logic                            is_jump;

    // Gather the later stages into arrays indexed EX, MEM, WB
    always_comb begin
        stage_dst[ST_EX]   = ex_dst;
        stage_dst[ST_MEM]  = mem_dst;
        stage_dst[ST_WB]   = wb_dst;
        stage_kind[ST_EX]  = ex_kind;
        stage_kind[ST_MEM] = mem_kind;
        stage_kind[ST_WB]  = wb_kind;
        op_src[0]          = id_src_a;
        op_src[1]          = id_src_b;
    end

    // One hazard evaluator per comparator operand
    for (genvar o = 0; o < N_OPS; o++) begin : g_op
        bhu_operand #(.REG_AW(REG_AW)) u_operand (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (op_src[o]),
            .dst        (stage_dst),
            .kind       (stage_kind),
            .need_stall (op_stall[o]),
            .sel        (op_sel[o])
        );
    end

    // Decode the instruction kind
    always_comb begin
        is_branch = (id_kind_e'(id_kind) == ID_BRANCH);
        is_jump   = (id_kind_e'(id_kind) == ID_JUMP);
    end

    // Stall only for a branch whose operand is not ready
    always_comb begin
        stall = is_branch && (|op_stall);
    end

    // Flush the wrong-path fetch; a stall defers the decision
    always_comb begin
        fetch_flush = !stall && (is_jump || (is_branch && id_taken));
    end

    // Selects matter only to the comparator, so only for branches
    always_comb begin
        fwd_sel_a = is_branch ? op_sel[0] : SRC_RF;
        fwd_sel_b = is_branch ? op_sel[1] : SRC_RF;
    end

    // R1: a jump always flushes and never waits
    a_r1_jump_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 2'd2) |-> (fetch_flush && !stall));

    // R8: stall and flush are never raised together
    a_r8_stall_over_flush: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !fetch_flush);

    // R9: plain instructions are invisible to the unit
    a_r9_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 2'd0) |-> (!stall && !fetch_flush && fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

    // R3: an ALU writer in EX on a branch source holds decode
    a_r3_alu_in_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 2'd1 && ex_kind == 2'd1 && ex_dst != '0 &&
         (ex_dst == id_src_a || ex_dst == id_src_b)) |-> stall);

    // R2: a branch without stall flushes exactly when taken
    a_r2_branch_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 2'd1 && !stall) |-> (fetch_flush == id_taken));

endmodule

// File: tb/test_branch_hazard_unit.sv
// Directed bench for the decode-stage branch hazard unit.
module test_branch_hazard_unit;

    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    id_kind;
    logic          id_taken;
    logic [AW-1:0] id_src_a, id_src_b;
    logic [1:0]    ex_kind, mem_kind, wb_kind;
    logic [AW-1:0] ex_dst, mem_dst, wb_dst;
    logic          stall, fetch_flush;
    logic [1:0]    fwd_sel_a, fwd_sel_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    branch_hazard_unit #(.REG_AW(AW)) i_branch_hazard_unit (
        .clk(clk), .rst_n(rst_n),
        .id_kind(id_kind), .id_taken(id_taken),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_kind(ex_kind), .ex_dst(ex_dst),
        .mem_kind(mem_kind), .mem_dst(mem_dst),
        .wb_kind(wb_kind), .wb_dst(wb_dst),
        .stall(stall), .fetch_flush(fetch_flush),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    // Put every input to an idle value
    task automatic idle();
        id_kind = 2'd0; id_taken = 1'b0;
        id_src_a = '0; id_src_b = '0;
        ex_kind = 2'd0; mem_kind = 2'd0; wb_kind = 2'd0;
        ex_dst = '0; mem_dst = '0; wb_dst = '0;
    endtask

    // Compare all outputs two time units after the falling edge
    task automatic expect_out(string req, logic e_stall, logic e_flush,
                              logic [1:0] e_a, logic [1:0] e_b);
        #2;
        n_checks++;
        if ({stall, fetch_flush, fwd_sel_a, fwd_sel_b} !== {e_stall, e_flush, e_a, e_b}) begin
            n_fail++;
            $display("FAIL %s: stall/flush/a/b actual %b/%b/%0d/%0d expected %b/%b/%0d/%0d",
                     req, stall, fetch_flush, fwd_sel_a, fwd_sel_b,
                     e_stall, e_flush, e_a, e_b);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    // R9: idle outputs in and after reset
    task automatic t_reset_state();
        idle();
        expect_out("R9 reset", 0, 0, 0, 0);
    endtask

    // R1: a jump flushes even with a load racing in EX
    task automatic t_jump();
        next_cycle(); idle();
        id_kind = 2'd2; id_src_a = 5'd3; ex_kind = 2'd2; ex_dst = 5'd3;
        expect_out("R1 jump", 0, 1, 0, 0);
    endtask

    // R2: clean branch, taken and not taken
    task automatic t_branch_plain();
        next_cycle(); idle();
        id_kind = 2'd1; id_src_a = 5'd4; id_src_b = 5'd5; id_taken = 1'b1;
        ex_kind = 2'd1; ex_dst = 5'd9;
        expect_out("R2 taken", 0, 1, 0, 0);
        next_cycle();
        id_taken = 1'b0;
        expect_out("R2 not taken", 0, 0, 0, 0);
    endtask

    // R3 and R8: ALU writer in EX stalls, taken flush is held back
    task automatic t_alu_in_ex();
        next_cycle(); idle();
        id_kind = 2'd1; id_src_a = 5'd1; id_src_b = 5'd7; id_taken = 1'b1;
        ex_kind = 2'd1; ex_dst = 5'd7;
        expect_out("R3 alu ex on b / R8", 1, 0, 0, 0);
        next_cycle();
        ex_dst = 5'd1; id_taken = 1'b0;
        expect_out("R3 alu ex on a", 1, 0, 0, 0);
    endtask

    // R4: load right before the branch, stepped through the pipeline
    task automatic t_load_sequence();
        next_cycle(); idle();
        id_kind = 2'd1; id_src_a = 5'd6; id_src_b = 5'd2; id_taken = 1'b1;
        ex_kind = 2'd2; ex_dst = 5'd6;
        expect_out("R4 load in ex", 1, 0, 0, 0);
        next_cycle();
        ex_kind = 2'd0; ex_dst = '0; mem_kind = 2'd2; mem_dst = 5'd6;
        expect_out("R4 load in mem", 1, 0, 0, 0);
        next_cycle();
        mem_kind = 2'd0; mem_dst = '0; wb_kind = 2'd2; wb_dst = 5'd6;
        expect_out("R4/R6 load reaches wb", 0, 1, 2, 0);
    endtask

    // R5: ALU result in MEM forwards
    task automatic t_alu_in_mem();
        next_cycle(); idle();
        id_kind = 2'd1; id_src_a = 5'd8; id_src_b = 5'd10;
        mem_kind = 2'd1; mem_dst = 5'd10;
        expect_out("R5 mem fwd b", 0, 0, 0, 1);
    endtask

    // R6: WB forwarding and MEM priority
    task automatic t_wb_forward();
        next_cycle(); idle();
        id_kind = 2'd1; id_src_a = 5'd11; id_src_b = 5'd12; id_taken = 1'b1;
        wb_kind = 2'd1; wb_dst = 5'd12;
        expect_out("R6 wb alu fwd b", 0, 1, 0, 2);
        next_cycle();
        wb_dst = 5'd11; mem_kind = 2'd1; mem_dst = 5'd11;
        expect_out("R6 mem over wb", 0, 1, 1, 0);
    endtask

    // R7: register 0 is never a hazard
    task automatic t_zero_reg();
        next_cycle(); idle();
        id_kind = 2'd1; id_taken = 1'b1;
        ex_kind = 2'd2; mem_kind = 2'd1; wb_kind = 2'd1;
        expect_out("R7 zero sources", 0, 1, 0, 0);
    endtask

    // R9: a plain instruction ignores dependencies
    task automatic t_other_instr();
        next_cycle(); idle();
        id_kind = 2'd0; id_taken = 1'b1; id_src_a = 5'd13; id_src_b = 5'd14;
        ex_kind = 2'd2; ex_dst = 5'd13; mem_kind = 2'd1; mem_dst = 5'd14;
        expect_out("R9 other instr", 0, 0, 0, 0);
    endtask

    initial begin
        idle();
        t_reset_state();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_jump();
        t_branch_plain();
        t_alu_in_ex();
        t_load_sequence();
        t_alu_in_mem();
        t_wb_forward();
        t_zero_reg();
        t_other_instr();
        next_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule